// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a bank of general-purpose input lines and raises one shared, active-high interrupt when a selected edge occurs on any of them. Each line can be set to react to rising transitions, falling transitions, or both. A detected transition sets a sticky cause bit for that line. The cause bit holds until software clears it by writing a one to the matching bit of the clear register. A separate per-line event enable decides which cause bits are allowed to drive the interrupt.

Software reaches the block through a flat 32-bit register port with a byte offset, a write strobe and a combinational read path. Every input first crosses a two-flop synchronizer. An edge is found by comparing the synchronized value with its copy from the previous cycle. Only transitions are detected; there is no level mode. The pending-status register returns the cause bits ANDed with the event enables, which is the set of lines that currently hold the interrupt high.

Top module: `gpio_edge_irq`

## Requirements
- R1: A low-to-high transition on a line sets that line's cause bit only when the line's bit in the rise-select register (offset 0x44) is one.
- R2: A high-to-low transition on a line sets that line's cause bit only when the line's bit in the fall-select register (offset 0x48) is one.
- R3: With both select bits set for a line, a transition in either direction sets its cause bit. Other lines are not affected.
- R4: A set cause bit stays set, and keeps the interrupt high if enabled, until it is cleared. This holds whatever the input does afterwards.
- R5: Writing to the clear register (offset 0x98) clears each cause bit whose written bit is one. Bits written as zero leave their cause bits unchanged.
- R6: The event-enable register (offset 0x94) resets to all zeros. While it is zero, the interrupt output stays low even when cause bits are set.
- R7: The read-only status register (offset 0x80) returns the cause bits ANDed with the event enables. Writes to it have no effect.
- R8: The interrupt output is the OR of all bits of the status register. Cause bits are set regardless of the event enable. Setting the enable of a line whose cause is already set raises the interrupt in the cycle after that write.
- R9: If a selected edge and a clear of the same line occur in the same cycle, the cause bit ends up set.
- R10: The rise-select, fall-select and event-enable registers are read/write and reset to zero. The clear register reads as zero. Unmapped offsets read as zero and ignore writes.
- R11: An input change made before clock edge k sets the cause bit at clock edge k+2 and not earlier, because of the two synchronizer stages plus the cause register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpioIn | input | NUM_LINES | Asynchronous general-purpose input lines |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Shared active-high interrupt |

## Verification
The bench sweeps every line through all four rise/fall select combinations in both edge directions. It compares the full status word, so a swapped rise/fall select or a line that leaks into a neighbour shows up as a wrong bit. It targets an edge that lands in the same cycle as a clear of the same bit: a design that lets the clear win drops the event and reads zero. It also enables a line whose cause was captured while disabled; a design that gates capture with the enable never raises the interrupt. The bench checks the exact synchronizer latency, that clear bits written as zero have no effect, that the status register ignores writes, and that unmapped offsets read as zero, catching off-by-one pipelines and loose decoding.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  // Offsets kept where software drivers decode them.
  localparam logic [ADDR_W-1:0] OFS_RISE_SEL = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_FALL_SEL = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_PENDING  = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_EVT_EN   = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_CLEAR    = 8'h98;

  // Control-to-datapath bundle: configuration levels plus a clear strobe.
  typedef struct packed {
    logic [REG_W-1:0] riseSel;
    logic [REG_W-1:0] fallSel;
    logic [REG_W-1:0] evtEn;
    logic [REG_W-1:0] clrMask;
  } lineCtl_t;
endpackage

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [REG_W-1:0]  pendingVec,
  output lineCtl_t          ctl,
  output logic [REG_W-1:0]  regRdData
);
  localparam logic [REG_W-1:0] LINE_MASK = REG_W'((64'd1 << NUM_LINES) - 64'd1);

  logic [REG_W-1:0] riseQ, fallQ, evtQ;
  logic             wrRise, wrFall, wrEvt, wrClr;

  assign wrRise = regWrEn && (regAddr == OFS_RISE_SEL);
  assign wrFall = regWrEn && (regAddr == OFS_FALL_SEL);
  assign wrEvt  = regWrEn && (regAddr == OFS_EVT_EN);
  assign wrClr  = regWrEn && (regAddr == OFS_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      riseQ <= '0;
      fallQ <= '0;
      evtQ  <= '0;
    end else begin
      if (wrRise) riseQ <= regWrData & LINE_MASK;
      if (wrFall) fallQ <= regWrData & LINE_MASK;
      if (wrEvt)  evtQ  <= regWrData & LINE_MASK;
    end
  end

  always_comb begin
    ctl.riseSel = riseQ;
    ctl.fallSel = fallQ;
    ctl.evtEn   = evtQ;
    ctl.clrMask = wrClr ? (regWrData & LINE_MASK) : '0;
  end

  always_comb begin
    unique case (regAddr)
      OFS_RISE_SEL: regRdData = riseQ;
      OFS_FALL_SEL: regRdData = fallQ;
      OFS_EVT_EN:   regRdData = evtQ;
      OFS_PENDING:  regRdData = pendingVec;
      default:      regRdData = '0;
    endcase
  end

  // Configuration only moves on a write (R10).
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !regWrEn |=> ($stable(riseQ) && $stable(fallQ) && $stable(evtQ)));
endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] gpioIn,
  input  lineCtl_t             ctl,
  output logic [REG_W-1:0]     pendingVec,
  output logic                 irqOut
);
  logic [REG_W-1:0] riseSeen, fallSeen, edgeHit, causeQ, causeNext;

  for (genvar g = 0; g < REG_W; g++) begin : g_line
    if (g < NUM_LINES) begin : g_live
      logic syncA, syncB, prevB;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          syncA <= 1'b0;
          syncB <= 1'b0;
          prevB <= 1'b0;
        end else begin
          syncA <= gpioIn[g];
          syncB <= syncA;
          prevB <= syncB;
        end
      end
      assign riseSeen[g] = syncB & ~prevB;
      assign fallSeen[g] = ~syncB & prevB;
    end else begin : g_tie
      assign riseSeen[g] = 1'b0;
      assign fallSeen[g] = 1'b0;
    end
  end

  assign edgeHit   = (riseSeen & ctl.riseSel) | (fallSeen & ctl.fallSel);
  // A fresh edge wins over a same-cycle clear.
  assign causeNext = (causeQ & ~ctl.clrMask) | edgeHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) causeQ <= '0;
    else        causeQ <= causeNext;
  end

  assign pendingVec = causeQ & ctl.evtEn;
  assign irqOut     = |pendingVec;

  // Cause bits only fall when cleared (R4).
  p_cause_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(causeQ) & ~$past(ctl.clrMask)) & ~causeQ) == '0));

  // An edge always lands in the cause register, clear or not (R9).
  p_edge_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edgeHit) & ~causeQ) == '0));

  // New cause bits only appear on lines with some edge selected (R1).
  p_no_unselected_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((causeQ & ~$past(causeQ) & ~($past(ctl.riseSel) | $past(ctl.fallSel))) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] gpioIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic                 irqOut
);
  lineCtl_t         ctlBus;
  logic [REG_W-1:0] pendingVec;

  edge_irq_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .pendingVec (pendingVec),
    .ctl        (ctlBus),
    .regRdData  (regRdData)
  );

  edge_irq_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .gpioIn     (gpioIn),
    .ctl        (ctlBus),
    .pendingVec (pendingVec),
    .irqOut     (irqOut)
  );

  // No event enable, no interrupt (R6).
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlBus.evtEn == '0) |-> !irqOut);
endmodule

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
  localparam int NL = 32;
  localparam logic [7:0] A_RISE = 8'h44, A_FALL = 8'h48, A_PEND = 8'h80,
                         A_EVT = 8'h94, A_CLR = 8'h98, A_HOLE = 8'h4C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] gpioIn = '0;
  logic [7:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_irq #(.NUM_LINES(NL)) u_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .gpioIn(gpioIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negative edge; returns at a negative edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(1);

    // Reset state (R10, R6)
    rd(A_RISE, v); check("R10 rise reset", v, 0);
    rd(A_FALL, v); check("R10 fall reset", v, 0);
    rd(A_EVT, v);  check("R6 evt reset", v, 0);
    rd(A_PEND, v); check("R7 pending reset", v, 0);
    check("R6 irq reset", {31'b0, irqOut}, 0);

    // Register access (R10)
    wr(A_RISE, 32'hA5A5_A5A5); rd(A_RISE, v); check("R10 rise rw", v, 32'hA5A5_A5A5);
    wr(A_FALL, 32'h5A5A_5A5A); rd(A_FALL, v); check("R10 fall rw", v, 32'h5A5A_5A5A);
    wr(A_EVT, 32'hFFFF_0000);  rd(A_EVT, v);  check("R10 evt rw", v, 32'hFFFF_0000);
    wr(A_CLR, 32'hFFFF_FFFF);  rd(A_CLR, v);  check("R10 clear reads zero", v, 0);
    wr(A_HOLE, 32'hFFFF_FFFF); rd(A_HOLE, v); check("R10 hole reads zero", v, 0);
    rd(A_RISE, v); check("R10 hole write ignored", v, 32'hA5A5_A5A5);
    wr(A_RISE, 0); wr(A_FALL, 0); wr(A_EVT, 0);

    // Latency (R11) and unselected fall (R2)
    wr(A_RISE, 32'hFFFF_FFFF); wr(A_EVT, 32'hFFFF_FFFF);
    gpioIn[3] = 1'b1;
    waitCyc(2); rd(A_PEND, v); check("R11 not before edge k+2", v, 0);
    waitCyc(1); rd(A_PEND, v); check("R11 set at edge k+2", v, 32'h8);
    wr(A_CLR, 32'h8);
    gpioIn[3] = 1'b0;
    waitCyc(4); rd(A_PEND, v); check("R2 fall unselected", v, 0);

    // Sweep every line and select mode (R1, R2, R3, R8)
    for (int ln = 0; ln < NL; ln++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] bitv;
        bitv = 32'h1 << ln;
        wr(A_RISE, m[0] ? bitv : 32'h0);
        wr(A_FALL, m[1] ? bitv : 32'h0);
        wr(A_CLR, 32'hFFFF_FFFF);
        gpioIn[ln] = 1'b1;
        waitCyc(4);
        rd(A_PEND, v);
        check(m[1] ? "R3 rise sweep" : "R1 rise sweep", v, m[0] ? bitv : 32'h0);
        check("R8 irq after rise", {31'b0, irqOut}, {31'b0, m[0]});
        wr(A_CLR, 32'hFFFF_FFFF);
        gpioIn[ln] = 1'b0;
        waitCyc(4);
        rd(A_PEND, v);
        check(m[0] ? "R3 fall sweep" : "R2 fall sweep", v, m[1] ? bitv : 32'h0);
        check("R8 irq after fall", {31'b0, irqOut}, {31'b0, m[1]});
        wr(A_CLR, 32'hFFFF_FFFF);
      end
    end

    // Sticky cause (R4) and write-one clear (R5)
    wr(A_RISE, 32'h20); wr(A_FALL, 0);
    gpioIn[5] = 1'b1; waitCyc(4);
    gpioIn[5] = 1'b0; waitCyc(10);
    rd(A_PEND, v); check("R4 sticky after pulse", v, 32'h20);
    check("R4 irq held", {31'b0, irqOut}, 1);
    wr(A_CLR, 32'h0);  rd(A_PEND, v); check("R5 zero write no effect", v, 32'h20);
    wr(A_CLR, 32'h10); rd(A_PEND, v); check("R5 other bit no effect", v, 32'h20);
    wr(A_CLR, 32'h20); rd(A_PEND, v); check("R5 one clears", v, 0);
    check("R5 irq drops", {31'b0, irqOut}, 0);

    // Enable gating (R6, R7, R8)
    wr(A_EVT, 0); wr(A_RISE, 32'hFFFF_FFFF);
    gpioIn[7] = 1'b1; waitCyc(4);
    rd(A_PEND, v); check("R6 pending gated", v, 0);
    check("R6 irq gated", {31'b0, irqOut}, 0);
    wr(A_EVT, 32'h80);
    check("R8 irq next cycle after enable", {31'b0, irqOut}, 1);
    rd(A_PEND, v); check("R7 pending masked", v, 32'h80);
    wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND, v); check("R7 write ignored", v, 32'h80);
    wr(A_EVT, 32'h200);
    rd(A_PEND, v); check("R7 other enable", v, 0);
    check("R8 irq off", {31'b0, irqOut}, 0);
    gpioIn[9] = 1'b1; waitCyc(4);
    rd(A_PEND, v); check("R7 both causes one enable", v, 32'h200);
    check("R8 irq on", {31'b0, irqOut}, 1);
    wr(A_CLR, 32'hFFFF_FFFF);
    gpioIn[7] = 1'b0; gpioIn[9] = 1'b0; waitCyc(4);

    // Edge colliding with clear (R9)
    wr(A_RISE, 32'h4); wr(A_FALL, 32'h4); wr(A_EVT, 32'h4);
    gpioIn[2] = 1'b1; waitCyc(4);
    rd(A_PEND, v); check("R9 setup", v, 32'h4);
    gpioIn[2] = 1'b0;
    waitCyc(2);
    wr(A_CLR, 32'h4);
    rd(A_PEND, v); check("R9 edge beats clear", v, 32'h4);
    wr(A_CLR, 32'h4);
    rd(A_PEND, v); check("R9 later clear works", v, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule